// File: doc/BRIEF.md
# Fractional-Ratio Clock Enable Bank

This block turns one fast reference clock into several slower clock-enable streams, all in the reference clock domain. Each stream fires on average 18 times for every F reference cycles, where F is a 6-bit fraction value programmed per output. F is limited to the range 18 to 35, so a stream runs between roughly half rate and full rate and never faster than the reference. Downstream logic qualifies its flops with the enable instead of using a derived clock.

Outputs are grouped into register words of four 8-bit lanes. The default configuration has six outputs: outputs 0 to 3 live in word 0 and outputs 4 and 5 in the low two lanes of word 1. In each lane, bits [5:0] hold F, bit 6 is the error flag (a write of 1 clears it), and bit 7 is an active-high gate that stops the output. Each output runs a small phase accumulator. A new F waits for the next pulse before it takes over, so a stream never changes ratio part-way through a period. A register read port returns the lane contents one cycle after the address is presented.

Top module: `fdiv_bank`

## Requirements
- R1: With F programmed while the output is gated and the gate then cleared, the output gives exactly floor(18*N/F) pulses in the first N cycles after the gate-clearing write, for any legal F.
- R2: A lane write is legal when its bits [5:0] lie in 18..35. A legal write loads the fraction and the gate (bit 7) of that lane, and readback shows {gate, error, fraction} in bits [7], [6] and [5:0].
- R3: A lane write whose fraction is below 18 or above 35 changes neither the fraction nor the gate of that lane.
- R4: An illegal lane write sets that output's error flag. The flag stays set until a legal or illegal write to the lane carries a 1 in bit 6. When a write is illegal and also carries that 1, the error flag ends up set.
- R5: While an output's gate bit is 1, its enable stays low and its stable flag is low, from the second cycle after the write.
- R6: A gated output restarts from a zero phase, so repeating gate, ungate and count with the same F gives the same pulse count.
- R7: Rewriting F on a running output drops its stable flag. The flag comes back within two cycles, once the next pulse has passed, and the new ratio then holds to within one pulse over any window.
- R8: A write reaches only the word at the write address. Lanes in other words keep their contents.
- R9: After reset every output is gated with F = 18, no error flags are set, all enables and stable flags are low, and word 0 reads 0x92929292.
- R10: Read data is registered: it reflects the word at the read address one cycle later, and lanes with no output behind them read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Word index of the write |
| wr_data | input | 32 | Four 8-bit lanes: [5:0] fraction, [6] error clear, [7] gate |
| rd_addr | input | 1 | Word index of the read |
| rd_data | output | 32 | Registered readback: [5:0] fraction, [6] error, [7] gate per lane |
| clk_en | output | 6 | Per-output enable pulses |
| stable | output | 6 | Output ungated and running at its programmed fraction |
| frac_err | output | 6 | Sticky illegal-fraction flag per output |

## Verification
The bench goes after exact pulse counts from a zero phase at the extreme fractions 18 and 35 and at random ones. A design that kept stale phase across a gate, or was off by one in its compare, gives a different count. It writes the boundary values 17, 36, 0 and 63, where a design with loose range checks would load them or fail to flag them. It also checks error-set against error-clear in the same write, where a wrong priority loses the flag. Rewriting F on a live output must hold the stable flag low until the next pulse, and the rate bound afterwards catches a design that switched mid-period or never switched.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int FRAC_W   = 6;
  localparam int MULT     = 18;
  localparam int FRAC_MIN = 18;
  localparam int FRAC_MAX = 35;
  localparam int FRAC_RST = 18;
  localparam int LANE_W   = 8;
  localparam int ERR_BIT  = 6;
  localparam int GATE_BIT = 7;

  function automatic logic frac_legal(input logic [FRAC_W-1:0] f);
    return (int'(f) >= FRAC_MIN) && (int'(f) <= FRAC_MAX);
  endfunction
endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs
  import fdiv_pkg::*;
#(
  parameter int NUM_OUTS  = 6,
  parameter int LANES     = 4,
  localparam int NUM_WORDS = (NUM_OUTS + LANES - 1) / LANES,
  localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data,
  output logic [NUM_OUTS-1:0][FRAC_W-1:0]   prog_frac,
  output logic [NUM_OUTS-1:0]               gate,
  output logic [NUM_OUTS-1:0]               err
);
  localparam int SLOTS = NUM_WORDS * LANES;

  logic [SLOTS*LANE_W-1:0] rb_flat;
  logic [DATA_W-1:0]       rd_q;
  logic                    unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_lane
    localparam int W = i / LANES;
    localparam int L = i % LANES;
    logic [LANE_W-1:0] lane;
    logic              hit, ok;
    logic [FRAC_W-1:0] frac_q;
    logic              gate_q, err_q;

    assign lane = wr_data[L*LANE_W +: LANE_W];
    assign hit  = wr_en && (wr_addr == ADDR_W'(W));
    assign ok   = frac_legal(lane[FRAC_W-1:0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        frac_q <= FRAC_W'(FRAC_RST);
        gate_q <= 1'b1;
        err_q  <= 1'b0;
      end else begin
        if (hit && ok) begin
          frac_q <= lane[FRAC_W-1:0];
          gate_q <= lane[GATE_BIT];
        end
        if (hit && !ok)
          err_q <= 1'b1;
        else if (hit && lane[ERR_BIT])
          err_q <= 1'b0;
      end
    end

    assign prog_frac[i] = frac_q;
    assign gate[i]      = gate_q;
    assign err[i]       = err_q;
    assign rb_flat[i*LANE_W +: LANE_W] = {gate_q, err_q, frac_q};

    // R3: an out-of-range fraction leaves the lane untouched
    a_r3_bad_write_ignored: assert property (@(posedge clk) disable iff (rst)
      (hit && !ok) |=> ($stable(frac_q) && $stable(gate_q)));
    // R2: the stored fraction is always a legal one
    a_r2_frac_legal: assert property (@(posedge clk) disable iff (rst)
      frac_legal(frac_q));
    // R4: an illegal write leaves the error flag set
    a_r4_err_set: assert property (@(posedge clk) disable iff (rst)
      (hit && !ok) |=> err_q);
    // R4: without a write to this lane the flag holds
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
      (err_q && !hit) |=> err_q);
  end

  for (genvar s = NUM_OUTS; s < SLOTS; s++) begin : g_empty
    assign rb_flat[s*LANE_W +: LANE_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (int'(rd_addr) < NUM_WORDS)
      rd_q <= rb_flat[int'(rd_addr)*DATA_W +: DATA_W];
    else
      rd_q <= '0;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/fdiv_chan.sv
module fdiv_chan
  import fdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic [FRAC_W-1:0] prog_frac,
  output logic              pulse,
  output logic              stable
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] act_q;
  logic              pulse_q;
  logic [FRAC_W:0]   sum;
  logic              wrap;

  assign sum  = {1'b0, acc_q} + (FRAC_W+1)'(MULT);
  assign wrap = sum >= {1'b0, act_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      act_q   <= FRAC_W'(FRAC_RST);
      pulse_q <= 1'b0;
    end else if (gate) begin
      acc_q   <= '0;
      act_q   <= prog_frac;
      pulse_q <= 1'b0;
    end else if (wrap) begin
      acc_q   <= FRAC_W'(sum - {1'b0, act_q});
      act_q   <= prog_frac;
      pulse_q <= 1'b1;
    end else begin
      acc_q   <= FRAC_W'(sum);
      pulse_q <= 1'b0;
    end
  end

  assign pulse  = pulse_q;
  assign stable = !gate && (act_q == prog_frac);

  // R5: a gated channel emits nothing
  a_r5_gated_quiet: assert property (@(posedge clk) disable iff (rst)
    gate |=> !pulse_q);
  // R6: a gated channel parks its phase at zero
  a_r6_gated_zero: assert property (@(posedge clk) disable iff (rst)
    gate |=> (acc_q == '0));
  // R7: the working fraction changes only at a pulse or while gated
  a_r7_switch_at_pulse: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> (pulse_q || $past(gate)));
  // R1: the residual phase stays below the working fraction
  a_r1_phase_bound: assert property (@(posedge clk) disable iff (rst)
    acc_q < act_q);
endmodule

// File: rtl/fdiv_bank.sv
module fdiv_bank
  import fdiv_pkg::*;
#(
  parameter int NUM_OUTS = 6,
  parameter int LANES    = 4,
  localparam int NUM_WORDS = (NUM_OUTS + LANES - 1) / LANES,
  localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_OUTS-1:0] clk_en,
  output logic [NUM_OUTS-1:0] stable,
  output logic [NUM_OUTS-1:0] frac_err
);
  logic [NUM_OUTS-1:0][FRAC_W-1:0] prog_frac;
  logic [NUM_OUTS-1:0]             gate;

  fdiv_regs #(.NUM_OUTS(NUM_OUTS), .LANES(LANES)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .prog_frac(prog_frac), .gate(gate), .err(frac_err)
  );

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_chan
    fdiv_chan u_chan (
      .clk(clk), .rst(rst),
      .gate(gate[i]), .prog_frac(prog_frac[i]),
      .pulse(clk_en[i]), .stable(stable[i])
    );
  end
endmodule

// File: tb/fdiv_bank_test.sv
`timescale 1ns/1ps
module fdiv_bank_test;
  localparam int NO = 6;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [0:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [NO-1:0] clk_en, stable, frac_err;

  int total = 0, bad = 0;
  int sh_frac [NO];
  bit sh_gate [NO];
  bit sh_err  [NO];

  always #2.5 clk = ~clk;

  fdiv_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_en(clk_en), .stable(stable),
    .frac_err(frac_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic bit legal(input int f);
    return f >= 18 && f <= 35;
  endfunction

  function automatic logic [7:0] exp_lane(input int c);
    if (c >= NO) return 8'h00;
    return {sh_gate[c], sh_err[c], 6'(sh_frac[c])};
  endfunction

  // writes lane c with fraction f, gate g, error-clear bit clr; other lanes keep shadow values
  task automatic set_lane(input int c, input int f, input bit g, input bit clr = 1'b0);
    int w = c / 4;
    logic [31:0] d = '0;
    for (int l = 0; l < 4; l++) begin
      int cc = w * 4 + l;
      if (cc < NO) d[l*8 +: 8] = {sh_gate[cc], 1'b0, 6'(sh_frac[cc])};
    end
    d[(c%4)*8 +: 8] = {g, clr, 6'(f)};
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'(w); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (legal(f)) begin sh_frac[c] = f; sh_gate[c] = g; end
    if (!legal(f)) sh_err[c] = 1'b1;
    else if (clr) sh_err[c] = 1'b0;
  endtask

  task automatic rd_word(input int w, output logic [31:0] v);
    @(negedge clk);
    rd_addr = 1'(w);
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic count(input int c, input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (clk_en[c]) k++;
    end
  endtask

  task automatic check_word(input int w, input string req);
    logic [31:0] v, e;
    rd_word(w, v);
    for (int l = 0; l < 4; l++) e[l*8 +: 8] = exp_lane(w*4 + l);
    chk(v == e, req, v, e);
  endtask

  // gated program, ungate, count from zero phase
  task automatic run_exact(input int c, input int f, input int n, input string req);
    int k;
    set_lane(c, f, 1'b1);
    set_lane(c, f, 1'b0);
    chk(stable[c] == 1'b1, "R7 stable after ungate", stable[c], 1);
    count(c, n, k);
    chk(k == (18*n)/f, req, k, (18*n)/f);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int k, k2, waitc;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NO; i++) begin sh_frac[i] = 18; sh_gate[i] = 1; sh_err[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9 reset state
    chk(clk_en == '0, "R9 enables", clk_en, 0);
    chk(stable == '0, "R9 stable", stable, 0);
    chk(frac_err == '0, "R9 errors", frac_err, 0);
    rd_word(0, v);
    chk(v == 32'h92929292, "R9 word0", v, 32'h92929292);
    // R10 empty lanes read zero
    rd_word(1, v);
    chk(v == 32'h00009292, "R10 word1", v, 32'h00009292);

    // R1 extremes
    run_exact(0, 18, 100, "R1 F=18");
    run_exact(1, 35, 140, "R1 F=35");
    run_exact(4, 27, 90, "R1 F=27 word1");

    // R6 deterministic restart
    run_exact(2, 23, 77, "R6 first");
    run_exact(2, 23, 77, "R6 repeat");

    // R5 gating
    set_lane(0, 18, 1'b1);
    @(posedge clk); @(negedge clk);
    count(0, 50, k);
    chk(k == 0, "R5 gated pulses", k, 0);
    chk(stable[0] == 1'b0, "R5 gated stable", stable[0], 0);

    // R2 readback after legal writes
    check_word(0, "R2 word0 readback");
    check_word(1, "R2 word1 readback");

    // R3/R4 illegal boundary writes
    begin
      int bads[4] = '{17, 36, 0, 63};
      foreach (bads[j]) begin
        set_lane(3, bads[j], ~sh_gate[3]);
        check_word(0, "R3 illegal ignored");
        chk(frac_err[3] == 1'b1, "R4 error set", frac_err[3], 1);
      end
    end
    set_lane(3, 20, 1'b1);
    chk(frac_err[3] == 1'b1, "R4 error held", frac_err[3], 1);
    set_lane(3, 40, 1'b1, 1'b1);
    chk(frac_err[3] == 1'b1, "R4 set beats clear", frac_err[3], 1);
    set_lane(3, 20, 1'b1, 1'b1);
    chk(frac_err[3] == 1'b0, "R4 cleared", frac_err[3], 0);
    check_word(0, "R4 readback after clear");

    // R8 word isolation
    set_lane(5, 31, 1'b1);
    set_lane(1, 19, 1'b1);
    check_word(1, "R8 word1 kept");
    set_lane(5, 63, 1'b1);
    check_word(0, "R8 word0 kept");
    chk(frac_err[5] && !frac_err[1], "R8 error lane", frac_err, 6'b100000);

    // R7 reprogram while running
    run_exact(1, 35, 40, "R1 pre-switch");
    set_lane(1, 19, 1'b0);
    chk(stable[1] == 1'b0, "R7 stable drops", stable[1], 0);
    waitc = 0;
    while (!stable[1] && waitc < 5) begin
      @(posedge clk); @(negedge clk);
      waitc++;
    end
    chk(waitc >= 1 && waitc <= 2, "R7 switch latency", waitc, 2);
    count(1, 190, k);
    k2 = (18*190)/19;
    chk(k >= k2 && k <= k2 + 1, "R7 new rate", k, k2);

    // random runs
    for (int it = 0; it < 24; it++) begin
      int c = $urandom % NO;
      int f = 18 + ($urandom % 18);
      int n = 40 + ($urandom % 200);
      run_exact(c, f, n, "R1 random");
      if ($urandom % 2) begin
        int bf = ($urandom % 2) ? ($urandom % 18) : 36 + ($urandom % 28);
        set_lane(c, bf, 1'b0);
        check_word(c / 4, "R3 random illegal");
      end
      set_lane(c, sh_frac[c], 1'b1, 1'b1);
    end

    finish_up();
  end
endmodule